// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller with Fast-Path Routing

This block gathers 128 level-sensitive interrupt lines, organised as four groups of 32, and condenses them into three outputs: a normal interrupt request, a fast interrupt request and a wake request. Each line is numbered; its group is the number divided by 32 and its bit inside the group is the number modulo 32. Every line has an enable bit, a routing bit that sends it to the normal or to the fast output, and a wake bit. Lines pass through a synchronizer before they can be seen as pending. Pending state follows the synchronized level directly and is never latched.

Software reaches everything through a 32-bit register port with a single byte address. Reads are combinational from the address. Writes take effect on the rising clock edge while the write strobe is high. Enables can only be changed through a write-one-to-set window and a write-one-to-clear window. A global on bit gates both request outputs, and a priority threshold set to zero blocks every line. Before entering low power, software must win a hold-off handshake; until it does, the wake masks are inert. A software trigger register lets any line be asserted from the register port.

Top module: `intc_banked`

## Requirements
- R1: After reset every enable, routing, wake and software-trigger bit is 0, the hold-off flag reads 0, and irqOut, fiqOut and wakeOut are low.
- R2: Writing group g's set window at 0x100+4g makes every 1 bit enabled and leaves 0 bits unchanged. Reading either 0x100+4g or 0x180+4g returns the group's enable mask.
- R3: Writing group g's clear window at 0x180+4g disables every 1 bit and leaves 0 bits unchanged.
- R4: Group g's routing word at 0x080+4g, read/write, sends a pending line to irqOut when its bit is 1 and to fiqOut when its bit is 0.
- R5: The read-only pending word at 0xD80+4g shows, at bit n mod 32 of group n/32, the lines that are asserted, enabled and allowed by the priority threshold.
- R6: A change on srcIn reaches the pending word and the request outputs at the second rising edge after it is applied, and not before.
- R7: While bit 0 of the control word (0x000) is 0, irqOut and fiqOut stay low, and the pending word still reports pending lines.
- R8: The priority threshold at 0x00C, 8 bits wide, passes every line when nonzero and blocks every line (pending word 0, outputs low) when zero.
- R9: Writing 1 in bit 0 of the hold-off word (0x014) sets its flag, which reads back in bit 0, only if no line is pending at that edge; otherwise the flag reads 0. Writing 0 there clears the flag.
- R10: wakeOut is high exactly when the hold-off flag is set and some asserted line has its bit set in the group's wake word at 0xE00+4g, regardless of enable, routing and control bit 0.
- R11: Writing the trigger word at 0xF00 with bit 31 set asserts the line numbered by bits 6:0; writing it with bit 31 clear releases that line. A triggered line behaves like a synchronized asserted input from the edge after the write.
- R12: The control word (0x000, 32 bits), the threshold (0x00C) and the synchronizer control word (0x010, 32 bits) read back the values written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 12 | Byte address for reads and writes; word aligned |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| srcIn | input | 128 | Level-sensitive interrupt lines, line n at bit n |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| wakeOut | output | 1 | Wake request for the low-power logic |

## Verification
On every cycle, the assertions check that the outputs are silenced by a clear control bit or a zero threshold, that wake never rises without the hold-off flag, and that enable bits rise only after a set-window write and fall only after a clear-window write. Only the bench scenarios can show the two-edge synchronizer latency and the per-bit routing split across groups. They also cover the hold-off refusal when something is pending, the software trigger path, and the bit placement of the pending word.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_W     = 32;
  localparam int NUM_SRC    = NUM_BANKS * BANK_W;
  localparam int SRC_IDX_W  = $clog2(NUM_SRC);
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int PRIO_W     = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_PRIO, RD_SYNC, RD_HOLD,
    RD_ROUTE, RD_ENABLE, RD_PEND, RD_WAKE
  } rdSel_e;

  typedef struct packed {
    logic                  wrCtrl;
    logic                  wrPrio;
    logic                  wrSync;
    logic                  wrHold;
    logic                  wrSoft;
    logic [NUM_BANKS-1:0]  wrRoute;
    logic [NUM_BANKS-1:0]  wrEnSet;
    logic [NUM_BANKS-1:0]  wrEnClr;
    logic [NUM_BANKS-1:0]  wrWake;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } regStb_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStb_t           stb
);
  logic [ADDR_W-5:0]     winSel;
  logic [1:0]            wordIdx;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  aligned;
  logic                  bankOk;

  assign winSel  = addr[ADDR_W-1:4];
  assign wordIdx = addr[3:2];
  assign bankIdx = BANK_IDX_W'(wordIdx);
  assign aligned = (addr[1:0] == 2'b00);
  assign bankOk  = (32'(wordIdx) < NUM_BANKS);

  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_NONE;
    stb.rdBank = bankIdx;
    if (aligned) begin
      unique case (winSel)
        8'h00: begin
          if (wordIdx == 2'd0) begin
            stb.rdSel = RD_CTRL; stb.wrCtrl = wrEn;
          end else if (wordIdx == 2'd3) begin
            stb.rdSel = RD_PRIO; stb.wrPrio = wrEn;
          end
        end
        8'h01: begin
          if (wordIdx == 2'd0) begin
            stb.rdSel = RD_SYNC; stb.wrSync = wrEn;
          end else if (wordIdx == 2'd1) begin
            stb.rdSel = RD_HOLD; stb.wrHold = wrEn;
          end
        end
        8'h08: if (bankOk) begin
          stb.rdSel = RD_ROUTE; stb.wrRoute[bankIdx] = wrEn;
        end
        8'h10: if (bankOk) begin
          stb.rdSel = RD_ENABLE; stb.wrEnSet[bankIdx] = wrEn;
        end
        8'h18: if (bankOk) begin
          stb.rdSel = RD_ENABLE; stb.wrEnClr[bankIdx] = wrEn;
        end
        8'hD8: if (bankOk) stb.rdSel = RD_PEND;
        8'hE0: if (bankOk) begin
          stb.rdSel = RD_WAKE; stb.wrWake[bankIdx] = wrEn;
        end
        8'hF0: if (wordIdx == 2'd0) stb.wrSoft = wrEn;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              wakeOut
);
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] softReg;
  logic [NUM_SRC-1:0] level, enFlat, routeFlat, wakeFlat, pendAll;
  logic [BANK_W-1:0]  enReg    [NUM_BANKS];
  logic [BANK_W-1:0]  routeReg [NUM_BANKS];
  logic [BANK_W-1:0]  wakeReg  [NUM_BANKS];
  logic [DATA_W-1:0]  ctrlReg, syncReg;
  logic [PRIO_W-1:0]  prioReg;
  logic               holdReg;
  logic               prioOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= srcIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[b]    <= '0;
        routeReg[b] <= '0;
        wakeReg[b]  <= '0;
      end else begin
        if (stb.wrEnSet[b])      enReg[b] <= enReg[b] | wrData;
        else if (stb.wrEnClr[b]) enReg[b] <= enReg[b] & ~wrData;
        if (stb.wrRoute[b]) routeReg[b] <= wrData;
        if (stb.wrWake[b])  wakeReg[b]  <= wrData;
      end
    end
    assign enFlat[b*BANK_W +: BANK_W]    = enReg[b];
    assign routeFlat[b*BANK_W +: BANK_W] = routeReg[b];
    assign wakeFlat[b*BANK_W +: BANK_W]  = wakeReg[b];
  end

  assign level    = syncQ[SYNC_STAGES-1] | softReg;
  assign prioOpen = |prioReg;
  assign pendAll  = level & enFlat & {NUM_SRC{prioOpen}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      syncReg <= '0;
      prioReg <= '0;
      holdReg <= 1'b0;
      softReg <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= wrData;
      if (stb.wrSync) syncReg <= wrData;
      if (stb.wrPrio) prioReg <= wrData[PRIO_W-1:0];
      if (stb.wrHold) holdReg <= wrData[0] & ~(|pendAll);
      if (stb.wrSoft) softReg[wrData[SRC_IDX_W-1:0]] <= wrData[DATA_W-1];
    end
  end

  assign irqOut  = ctrlReg[0] & |(pendAll & routeFlat);
  assign fiqOut  = ctrlReg[0] & |(pendAll & ~routeFlat);
  assign wakeOut = holdReg & |(level & wakeFlat);

  always_comb begin
    unique case (stb.rdSel)
      RD_CTRL:   rdData = ctrlReg;
      RD_PRIO:   rdData = DATA_W'(prioReg);
      RD_SYNC:   rdData = syncReg;
      RD_HOLD:   rdData = DATA_W'(holdReg);
      RD_ROUTE:  rdData = routeReg[stb.rdBank];
      RD_ENABLE: rdData = enReg[stb.rdBank];
      RD_PEND:   rdData = pendAll[stb.rdBank*BANK_W +: BANK_W];
      RD_WAKE:   rdData = wakeReg[stb.rdBank];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeOut
);
  regStb_t stb;

  intc_ctrl uCtrl (
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  intc_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .wakeOut (wakeOut)
  );
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               wakeOut,
  input logic               ctrlOn,
  input logic [PRIO_W-1:0]  prioVal,
  input logic               holdOn,
  input logic [NUM_SRC-1:0] enMask,
  input logic [NUM_BANKS-1:0] setStb,
  input logic [NUM_BANKS-1:0] clrStb
);
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlOn |-> (!irqOut && !fiqOut));

  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (prioVal == '0) |-> (!irqOut && !fiqOut));

  p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !holdOn |-> !wakeOut);

  p_enable_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|setStb) |-> ((enMask & ~$past(enMask)) == '0));

  p_enable_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|clrStb) |-> (($past(enMask) & ~enMask) == '0));
endmodule

bind intc_banked intc_banked_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .wakeOut (wakeOut),
  .ctrlOn  (uDp.ctrlReg[0]),
  .prioVal (uDp.prioReg),
  .holdOn  (uDp.holdReg),
  .enMask  (uDp.enFlat),
  .setStb  (stb.wrEnSet),
  .clrStb  (stb.wrEnClr)
);

// File: tb/test_intc_banked.sv
`timescale 1ns/1ps
module test_intc_banked;
  import intc_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [DATA_W-1:0]  rdData;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic               irqOut, fiqOut, wakeOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  intc_banked i_intc_banked (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut),
    .wakeOut(wakeOut)
  );

  typedef struct packed {
    logic [1:0]  bank;
    logic [31:0] en;
    logic [31:0] rt;
    logic [31:0] lvl;
    logic [31:0] pend;
    logic        irq;
    logic        fiq;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 32'h0000_00FF, 32'h0000_000F, 32'h0000_0011, 32'h0000_0011, 1'b1, 1'b1},
    '{2'd1, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0003_0003, 32'h0003_0000, 1'b1, 1'b0},
    '{2'd2, 32'h0F0F_0F0F, 32'h0000_0000, 32'hF0F0_F0F0, 32'h0000_0000, 1'b0, 1'b0},
    '{2'd3, 32'h8000_0000, 32'h0000_0000, 32'h8000_0001, 32'h8000_0000, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic clearEnables();
    for (int b = 0; b < NUM_BANKS; b++) wr(12'h180 + 12'(4*b), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irqOut), 0);
    check("R1 fiq", 32'(fiqOut), 0);
    check("R1 wake", 32'(wakeOut), 0);
    for (int b = 0; b < NUM_BANKS; b++) begin
      rd(12'h100 + 12'(4*b), d); check("R1 enable", d, 0);
      rd(12'h080 + 12'(4*b), d); check("R1 route", d, 0);
    end
    rd(12'h014, d); check("R1 hold", d, 0);

    // R12 readback
    wr(12'h000, 32'h8001_0001); rd(12'h000, d); check("R12 ctrl", d, 32'h8001_0001);
    wr(12'h00C, 32'h1F);        rd(12'h00C, d); check("R12 prio", d, 32'h1F);
    wr(12'h010, 32'h02);        rd(12'h010, d); check("R12 sync", d, 32'h02);

    // R2 set window, R3 clear window (group 3)
    wr(12'h10C, 32'h5); wr(12'h10C, 32'h2);
    rd(12'h10C, d); check("R2 set accumulates", d, 32'h7);
    rd(12'h18C, d); check("R2 read via clear window", d, 32'h7);
    wr(12'h18C, 32'h1); rd(12'h10C, d); check("R3 clear bit", d, 32'h6);
    wr(12'h18C, 32'h0); rd(12'h10C, d); check("R3 zero no effect", d, 32'h6);

    // R4/R5 vector table
    foreach (VECS[i]) begin
      clearEnables();
      srcIn = '0;
      wr(12'h080 + 12'(4*VECS[i].bank), VECS[i].rt);
      wr(12'h100 + 12'(4*VECS[i].bank), VECS[i].en);
      srcIn[32*VECS[i].bank +: 32] = VECS[i].lvl;
      repeat (3) @(negedge clk);
      rd(12'hD80 + 12'(4*VECS[i].bank), d); check("R5 pending word", d, VECS[i].pend);
      check("R4 irq routing", 32'(irqOut), 32'(VECS[i].irq));
      check("R4 fiq routing", 32'(fiqOut), 32'(VECS[i].fiq));
    end

    clearEnables();
    srcIn = '0;
    repeat (3) @(negedge clk);

    // R6 latency
    wr(12'h080, 32'h1);
    wr(12'h100, 32'h1);
    @(negedge clk); srcIn[0] = 1'b1;
    @(negedge clk); check("R6 not after one edge", 32'(irqOut), 0);
    @(negedge clk); check("R6 after two edges", 32'(irqOut), 1);

    // R7 control gate
    wr(12'h000, 32'h0);
    check("R7 irq gated", 32'(irqOut), 0);
    rd(12'hD80, d); check("R7 pending visible", d, 32'h1);
    wr(12'h000, 32'h8001_0001);
    check("R7 irq back", 32'(irqOut), 1);

    // R8 threshold zero
    wr(12'h00C, 32'h0);
    check("R8 irq blocked", 32'(irqOut), 0);
    rd(12'hD80, d); check("R8 pending blocked", d, 0);
    wr(12'h00C, 32'h1F);

    // R9 hold-off handshake
    wr(12'h014, 32'h1); rd(12'h014, d); check("R9 refused while pending", d, 0);
    srcIn = '0;
    repeat (3) @(negedge clk);
    wr(12'h014, 32'h1); rd(12'h014, d); check("R9 granted when idle", d, 1);

    // R10 wake
    wr(12'hE04, 32'h20);
    srcIn[37] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 wake on", 32'(wakeOut), 1);
    check("R10 no irq for disabled line", 32'(irqOut), 0);
    wr(12'h000, 32'h0);
    check("R10 wake with control off", 32'(wakeOut), 1);
    wr(12'h014, 32'h0);
    check("R10 wake off without hold", 32'(wakeOut), 0);
    wr(12'h000, 32'h8001_0001);
    srcIn = '0;
    repeat (3) @(negedge clk);

    // R11 software trigger on line 70 (group 2 bit 6)
    wr(12'h108, 32'h40);
    wr(12'h088, 32'h40);
    wr(12'hF00, 32'h8000_0046);
    check("R11 trigger irq", 32'(irqOut), 1);
    rd(12'hD88, d); check("R11 trigger pending", d, 32'h40);
    wr(12'hF00, 32'h0000_0046);
    check("R11 release irq", 32'(irqOut), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule